// File: doc/BRIEF.md
# Interrupt Request Steering Controller

This block sits between the peripheral interrupt sources of a chip and the three agents that can serve them: a set of DMA channels, a descriptor-driven transfer engine, and the CPU interrupt line. Every source produces single-cycle request pulses. Per-source configuration decides where each pulse goes. A DMA-claim bit withholds the source from the transfer engine and from the CPU. A transfer-enable bit chooses between the transfer engine and the CPU. A stop-after-transfer bit makes every completed transfer hand the source back to the CPU.

Each DMA channel picks one source with its own selector field. It latches activations from that source independently of the other paths. Sources routed to the transfer engine compete under a fixed priority. One activation is presented at a time, together with its source index, and held until the engine accepts it. When the engine reports completion with its counter at zero, or when the source's stop-after-transfer bit is set, the block clears that source's transfer-enable bit and raises the CPU interrupt flag. The CPU is therefore interrupted only after the data has moved.

Configuration is written through a small address/data port. Address 0 holds the claim bits, address 1 the transfer-enable bits and address 2 the stop-after-transfer bits, one bit per source at the source's index. Address 3+c holds the selector of DMA channel c in its low bits.

Top module: `irq_router`

## Requirements
- R1: One cycle after a pulse on the source whose index equals channel c's selector (address 3+c), `dma_req[c]` is 1. Channels that select the same source all activate.
- R2: `dma_req[c]` stays 1 until a cycle with `dma_ack[c]` high and drops one cycle later. If a new matching pulse arrives in the same cycle as the ack, the request stays 1.
- R3: A pulse on a source whose claim bit (address 0) is 1 raises neither `cpu_pend` for that source nor a transfer activation.
- R4: A pulse on an unclaimed source goes to the transfer engine when its transfer-enable bit (address 1) is 1. When that bit is 0, it sets `cpu_pend` for that source one cycle later.
- R5: Pending transfer activations are granted lowest index first. `xfer_req` is asserted two cycles after the pulse, and `xfer_src` is held stable until the cycle of `xfer_ack`. The next grant follows two cycles after the ack.
- R6: A completion (`xfer_done`) with `xfer_cnt_zero` = 1 clears the transfer-enable bit of `xfer_done_src` and sets its `cpu_pend` one cycle later. Later pulses of that source then go to the CPU.
- R7: When the stop-after-transfer bit (address 2) of the completing source is 1, any completion clears the enable bit and sets `cpu_pend`. A completion with neither condition leaves both unchanged.
- R8: For a source routed to the transfer engine, `cpu_pend` does not rise before a completion for that source.
- R9: `cpu_ack` clears `cpu_pend[cpu_ack_src]` one cycle later.
- R10: When a software write to address 1 and an automatic clear hit the same bit in the same cycle, the bit ends up 0. The other written bits take the written value.
- R11: The DMA path does not depend on the claim and enable bits. A claimed source still activates its channel, and an unclaimed CPU-routed source sets both `dma_req` and `cpu_pend`.
- R12: After reset, all requests and pending flags are 0, all configuration bits are 0 and all selectors point to source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | N_SRC | One-cycle request pulse per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | N_SRC | Configuration write data |
| dma_req | output | N_CH | DMA channel activation requests |
| dma_ack | input | N_CH | DMA channel accepts its activation |
| xfer_req | output | 1 | Transfer engine activation request |
| xfer_src | output | IDX_W | Source index of the held activation |
| xfer_ack | input | 1 | Transfer engine accepts the activation |
| xfer_done | input | 1 | Transfer completion pulse |
| xfer_done_src | input | IDX_W | Source index of the completed transfer |
| xfer_cnt_zero | input | 1 | Completion left the transfer counter at zero |
| cpu_pend | output | N_SRC | Pending CPU interrupt flags |
| cpu_ack | input | 1 | CPU acknowledges one interrupt |
| cpu_ack_src | input | IDX_W | Source index acknowledged by the CPU |

## Verification
The bench builds the block with 16 sources and 4 DMA channels. With that setting the selector uses its full 4-bit range. The priority contest can be run between indices as far apart as 2 and 11, and two channels can share one source. The directed scenarios also place an automatic clear and a software write on the same enable bit in the same cycle. A completion without the zero-counter or stop condition is shown to leave the routing unchanged by pulsing the source again afterwards.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    // Configuration register addresses
    localparam int REG_CLAIM = 0;
    localparam int REG_XEN   = 1;
    localparam int REG_STOP  = 2;
    localparam int REG_SEL0  = 3;
endpackage

// File: rtl/irq_router_cfg.sv
module irq_router_cfg
    import irq_router_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int N_CH   = 4,
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [N_SRC-1:0]        wdata,
    input  logic [N_SRC-1:0]        auto_clr,
    output logic [N_SRC-1:0]        claim,
    output logic [N_SRC-1:0]        xen,
    output logic [N_SRC-1:0]        stop,
    output logic [N_CH*IDX_W-1:0]   sel
);
    typedef struct packed {
        logic [N_SRC-1:0]            claim;
        logic [N_SRC-1:0]            xen;
        logic [N_SRC-1:0]            stop;
        logic [N_CH-1:0][IDX_W-1:0]  sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (int'(addr) == REG_CLAIM) cfg_d.claim = wdata;
            if (int'(addr) == REG_XEN)   cfg_d.xen   = wdata;
            if (int'(addr) == REG_STOP)  cfg_d.stop  = wdata;
            for (int c = 0; c < N_CH; c++) begin
                if (int'(addr) == REG_SEL0 + c) cfg_d.sel[c] = wdata[IDX_W-1:0];
            end
        end
        // hardware clear overrides the software write
        cfg_d.xen = cfg_d.xen & ~auto_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign claim = cfg_q.claim;
    assign xen   = cfg_q.xen;
    assign stop  = cfg_q.stop;
    assign sel   = cfg_q.sel;

    AST_AUTO_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clr != '0) |=> ((xen & $past(auto_clr)) == '0)); // R10
endmodule

// File: rtl/irq_router_dma_ch.sv
module irq_router_dma_ch #(
    parameter int N_SRC = 16,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_pulse,
    input  logic [IDX_W-1:0]  sel,
    input  logic              ack,
    output logic              req
);
    typedef struct packed {
        logic pend;
    } ch_t;

    ch_t  ch_d, ch_q;
    logic hit;

    always_comb begin
        hit  = (int'(sel) < N_SRC) ? src_pulse[sel] : 1'b0;
        ch_d = ch_q;
        if (ack) ch_d.pend = 1'b0;
        if (hit) ch_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign req = ch_q.pend;

    AST_DMA_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> req); // R1
    AST_DMA_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !req); // R2
endmodule

// File: rtl/irq_router_pick.sv
module irq_router_pick #(
    parameter int N_SRC = 16,
    parameter int IDX_W = 4
) (
    input  logic [N_SRC-1:0]  vec,
    output logic              valid,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        valid = |vec;
        idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int N_CH   = 4,
    parameter int IDX_W  = $clog2(N_SRC),
    parameter int ADDR_W = $clog2(N_CH + REG_SEL0)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_pulse,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [N_SRC-1:0]   cfg_wdata,
    output logic [N_CH-1:0]    dma_req,
    input  logic [N_CH-1:0]    dma_ack,
    output logic               xfer_req,
    output logic [IDX_W-1:0]   xfer_src,
    input  logic               xfer_ack,
    input  logic               xfer_done,
    input  logic [IDX_W-1:0]   xfer_done_src,
    input  logic               xfer_cnt_zero,
    output logic [N_SRC-1:0]   cpu_pend,
    input  logic               cpu_ack,
    input  logic [IDX_W-1:0]   cpu_ack_src
);
    typedef struct packed {
        logic [N_SRC-1:0]  xpend;
        logic [N_SRC-1:0]  cpend;
        logic              busy;
        logic [IDX_W-1:0]  gsrc;
    } st_t;

    st_t                   st_d, st_q;
    logic [N_SRC-1:0]      claim, xen, stop, auto_clr;
    logic [N_SRC-1:0]      to_xfer, to_cpu;
    logic [N_CH*IDX_W-1:0] sel;
    logic                  pick_valid;
    logic [IDX_W-1:0]      pick_idx;

    irq_router_cfg #(
        .N_SRC(N_SRC), .N_CH(N_CH), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .auto_clr(auto_clr),
        .claim(claim), .xen(xen), .stop(stop), .sel(sel)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        irq_router_dma_ch #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_ch (
            .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
            .sel(sel[c*IDX_W +: IDX_W]), .ack(dma_ack[c]), .req(dma_req[c])
        );
    end

    irq_router_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_pick (
        .vec(st_q.xpend), .valid(pick_valid), .idx(pick_idx)
    );

    // completion handling: hand the source back to the CPU
    always_comb begin
        auto_clr = '0;
        if (xfer_done && int'(xfer_done_src) < N_SRC) begin
            if (xfer_cnt_zero || stop[xfer_done_src]) auto_clr[xfer_done_src] = 1'b1;
        end
    end

    always_comb begin
        to_xfer = src_pulse & ~claim & xen;
        to_cpu  = src_pulse & ~claim & ~xen;
        st_d    = st_q;
        if (st_q.busy && xfer_ack) begin
            st_d.xpend[st_q.gsrc] = 1'b0;
            st_d.busy             = 1'b0;
        end
        st_d.xpend = st_d.xpend | to_xfer;
        if (cpu_ack && int'(cpu_ack_src) < N_SRC) st_d.cpend[cpu_ack_src] = 1'b0;
        st_d.cpend = st_d.cpend | to_cpu | auto_clr;
        if (!st_q.busy && pick_valid) begin
            st_d.busy = 1'b1;
            st_d.gsrc = pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xfer_req = st_q.busy;
    assign xfer_src = st_q.gsrc;
    assign cpu_pend = st_q.cpend;

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_src))); // R5
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req) |->
            (($past(st_q.xpend) & ((N_SRC'(1) << xfer_src) - N_SRC'(1))) == '0)); // R5

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        AST_CLAIM_NO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
            (src_pulse[i] && claim[i] && !cpu_pend[i] && !auto_clr[i])
                |=> !cpu_pend[i]); // R3
        AST_CPU_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(cpu_pend[i]) && $past(xen[i])) |->
                $past(xfer_done && int'(xfer_done_src) == i)); // R8
    end
endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
    localparam int N_SRC  = 16;
    localparam int N_CH   = 4;
    localparam int IDX_W  = 4;
    localparam int ADDR_W = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N_SRC-1:0]   src_pulse = '0;
    logic               cfg_we = 1'b0;
    logic [ADDR_W-1:0]  cfg_addr = '0;
    logic [N_SRC-1:0]   cfg_wdata = '0;
    logic [N_CH-1:0]    dma_req;
    logic [N_CH-1:0]    dma_ack = '0;
    logic               xfer_req;
    logic [IDX_W-1:0]   xfer_src;
    logic               xfer_ack = 1'b0;
    logic               xfer_done = 1'b0;
    logic [IDX_W-1:0]   xfer_done_src = '0;
    logic               xfer_cnt_zero = 1'b0;
    logic [N_SRC-1:0]   cpu_pend;
    logic               cpu_ack = 1'b0;
    logic [IDX_W-1:0]   cpu_ack_src = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_router #(.N_SRC(N_SRC), .N_CH(N_CH)) i_irq_router (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dma_req(dma_req), .dma_ack(dma_ack),
        .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_ack(xfer_ack),
        .xfer_done(xfer_done), .xfer_done_src(xfer_done_src),
        .xfer_cnt_zero(xfer_cnt_zero),
        .cpu_pend(cpu_pend), .cpu_ack(cpu_ack), .cpu_ack_src(cpu_ack_src)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [N_SRC-1:0] d);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [N_SRC-1:0] m);
        src_pulse = m;
        step();
        src_pulse = '0;
    endtask

    task automatic ack_x();
        xfer_ack = 1'b1;
        step();
        xfer_ack = 1'b0;
    endtask

    task automatic ack_cpu(input int s);
        cpu_ack = 1'b1; cpu_ack_src = IDX_W'(s);
        step();
        cpu_ack = 1'b0;
    endtask

    task automatic done(input int s, input bit cz);
        xfer_done = 1'b1; xfer_done_src = IDX_W'(s); xfer_cnt_zero = cz;
        step();
        xfer_done = 1'b0; xfer_cnt_zero = 1'b0;
    endtask

    task automatic t_reset();
        chk(dma_req == '0, "R12 dma_req", 32'(dma_req), 0);
        chk(xfer_req == 1'b0, "R12 xfer_req", 32'(xfer_req), 0);
        chk(cpu_pend == '0, "R12 cpu_pend", 32'(cpu_pend), 0);
        pulse(16'h0001);   // all selectors at 0 after reset, enable bits 0
        chk(dma_req == 4'hF, "R12 selectors", 32'(dma_req), 32'hF);
        chk(cpu_pend == 16'h0001, "R12 enable", 32'(cpu_pend), 1);
        dma_ack = 4'hF; step(); dma_ack = '0;
        ack_cpu(0);
    endtask

    task automatic t_select();
        wr(3, 16'd5); wr(4, 16'd9); wr(5, 16'd5); wr(6, 16'd15);
        pulse(16'h0020);
        chk(dma_req == 4'b0101, "R1 shared source", 32'(dma_req), 32'b0101);
        dma_ack = 4'b0001; step(); dma_ack = '0;
        chk(dma_req == 4'b0100, "R2 ack clears", 32'(dma_req), 32'b0100);
        step();
        chk(dma_req == 4'b0100, "R2 held", 32'(dma_req), 32'b0100);
        dma_ack = 4'b0100; src_pulse = 16'h0020; step(); dma_ack = '0; src_pulse = '0;
        chk(dma_req == 4'b0101, "R2 set beats ack", 32'(dma_req), 32'b0101);
        dma_ack = 4'b0101; step(); dma_ack = '0;
        pulse(16'h8200);
        chk(dma_req == 4'b1010, "R1 sel 9 and 15", 32'(dma_req), 32'b1010);
        dma_ack = 4'b1010; step(); dma_ack = '0;
        chk(dma_req == '0, "R2 all cleared", 32'(dma_req), 0);
        ack_cpu(5); ack_cpu(9); ack_cpu(15);
    endtask

    task automatic t_cpu_path();
        wr(3, 16'd3);
        pulse(16'h0008);
        chk(cpu_pend == 16'h0008, "R4 cpu route", 32'(cpu_pend), 32'h8);
        chk(dma_req[0] == 1'b1, "R11 dma and cpu", 32'(dma_req), 1);
        step();
        chk(xfer_req == 1'b0, "R4 no xfer", 32'(xfer_req), 0);
        ack_cpu(3);
        chk(cpu_pend == '0, "R9 cpu ack", 32'(cpu_pend), 0);
        dma_ack = 4'b0001; step(); dma_ack = '0;
    endtask

    task automatic t_claim();
        wr(0, 16'h0180); wr(1, 16'h0080); wr(6, 16'd7);
        pulse(16'h0180);
        chk(cpu_pend == '0, "R3 claim blocks cpu", 32'(cpu_pend), 0);
        chk(dma_req[3] == 1'b1, "R11 claimed dma", 32'(dma_req), 32'h8);
        step(); step();
        chk(xfer_req == 1'b0, "R3 claim blocks xfer", 32'(xfer_req), 0);
        dma_ack = 4'b1000; step(); dma_ack = '0;
        wr(0, 16'h0000); wr(1, 16'h0000);
    endtask

    task automatic t_prio();
        wr(1, 16'h0844);
        pulse(16'h0800);
        step();
        chk(xfer_req && xfer_src == 4'd11, "R4 R5 first grant", 32'(xfer_src), 11);
        pulse(16'h0044);
        step(); step();
        chk(xfer_req && xfer_src == 4'd11, "R5 held until ack", 32'(xfer_src), 11);
        ack_x();
        step();
        chk(xfer_req && xfer_src == 4'd2, "R5 lowest first", 32'(xfer_src), 2);
        chk(cpu_pend == '0, "R8 no cpu before done", 32'(cpu_pend), 0);
        ack_x();
        step();
        chk(xfer_req && xfer_src == 4'd6, "R5 next grant", 32'(xfer_src), 6);
        ack_x();
        step();
        chk(xfer_req == 1'b0, "R5 idle", 32'(xfer_req), 0);
    endtask

    task automatic t_done();
        wr(2, 16'h0040);
        done(2, 1'b0);
        chk(cpu_pend == '0, "R7 plain done no cpu", 32'(cpu_pend), 0);
        pulse(16'h0004);
        step();
        chk(xfer_req && xfer_src == 4'd2, "R7 enable kept", 32'(xfer_src), 2);
        ack_x();
        done(2, 1'b1);
        chk(cpu_pend == 16'h0004, "R6 cnt zero cpu", 32'(cpu_pend), 32'h4);
        ack_cpu(2);
        chk(cpu_pend == '0, "R9 ack", 32'(cpu_pend), 0);
        pulse(16'h0004);
        chk(cpu_pend == 16'h0004, "R6 rerouted to cpu", 32'(cpu_pend), 32'h4);
        step();
        chk(xfer_req == 1'b0, "R6 enable cleared", 32'(xfer_req), 0);
        ack_cpu(2);
        done(6, 1'b0);
        chk(cpu_pend == 16'h0040, "R7 stop bit cpu", 32'(cpu_pend), 32'h40);
        ack_cpu(6);
        pulse(16'h0040);
        step();
        chk(xfer_req == 1'b0 && cpu_pend == 16'h0040, "R7 enable cleared",
            32'(cpu_pend), 32'h40);
        ack_cpu(6);
        wr(2, 16'h0000);
    endtask

    task automatic t_race();
        cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 16'hFFFF;
        xfer_done = 1'b1; xfer_done_src = 4'd11; xfer_cnt_zero = 1'b1;
        step();
        cfg_we = 1'b0; xfer_done = 1'b0; xfer_cnt_zero = 1'b0;
        chk(cpu_pend == 16'h0800, "R10 done cpu", 32'(cpu_pend), 32'h800);
        ack_cpu(11);
        pulse(16'h0800);
        step();
        chk(xfer_req == 1'b0 && cpu_pend == 16'h0800, "R10 clear wins",
            32'(cpu_pend), 32'h800);
        ack_cpu(11);
        pulse(16'h0010);
        step();
        chk(xfer_req && xfer_src == 4'd4, "R10 other bits written", 32'(xfer_src), 4);
        ack_x();
        wr(1, 16'h0000);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_select();
        t_cpu_path();
        t_claim();
        t_prio();
        t_done();
        t_race();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule